// File: doc/BRIEF.md
# Load Value Prediction Table

This block guesses the data a load instruction will bring back from memory, using nothing but the address of the load instruction itself. Because that address is known as soon as the instruction is fetched, the front end can look up a guess long before the data address has been computed. The table is direct-mapped and carries no tags. Every load whose instruction address selects a given entry reads and overwrites that same entry, whether or not it is the load that last wrote it.

A guess is only speculative. When the real data comes back, the pipeline hands the block three things: the entry index it used, the value it was given, and the value memory actually returned. One cycle later the block reports whether the guess was right, and it writes the real value into that entry. The index travels with the verify request, so a late verification still updates the right entry. The block does not decide whether a guess is used, and it does not reissue dependent instructions.

Top module: `ldval_predictor`

## Requirements
- R1: After reset every entry holds zero, so a lookup of any index returns a prediction of all zeros.
- R2: `pred_vld` is high in exactly the cycle after a cycle in which `lookup_vld` is high, and low in every other cycle, including during reset.
- R3: The entry index is bits [PC_LSB+IDX_W-1 : PC_LSB] of `lookup_pc`, which are bits [11:2] with the default values. `pred_idx` reports this index. Two addresses that differ only above these bits select the same entry.
- R4: `pred_val` is the full VAL_W-bit value most recently written to the selected entry (64 bits by default).
- R5: `result_vld` is high in exactly the cycle after `verify_vld` is high, and `result_idx` equals the `verify_idx` of that request.
- R6: `result_hit` is 1 exactly when `verify_act` equals `verify_pred` in all VAL_W bits, and 0 when any single bit differs.
- R7: The verified entry is overwritten with `verify_act` whether or not the guess matched. A lookup presented two or more cycles after the verify request returns the new value.
- R8: A lookup presented in the cycle where `result_vld` is high for the same index returns the value the entry held before that write.
- R9: The lowest PC_LSB bits of `lookup_pc` do not affect which entry is selected.
- R10: When `verify_vld` is low, no entry changes, whatever values are on `verify_idx` and `verify_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears every entry |
| lookup_vld | input | 1 | Lookup request this cycle |
| lookup_pc | input | PC_W | Instruction address of the load being looked up |
| pred_vld | output | 1 | Prediction valid, one cycle after the lookup |
| pred_idx | output | IDX_W | Entry index that the prediction came from |
| pred_val | output | VAL_W | Predicted load value |
| verify_vld | input | 1 | Verify request this cycle |
| verify_idx | input | IDX_W | Entry index that the original lookup used |
| verify_pred | input | VAL_W | Value that was predicted |
| verify_act | input | VAL_W | Value actually returned by memory |
| result_vld | output | 1 | Verification result valid, one cycle after the request |
| result_hit | output | 1 | 1 when the prediction matched the actual value |
| result_idx | output | IDX_W | Entry index of the verified request |

## Verification
The bench aims at the cycle where the write lands in an entry. A lookup of that index in the same cycle must see the old value, and a lookup one cycle later must see the new one. A design that forwards the write would show the new value too early, and a design that delays the write a further stage would show it too late. Aliasing addresses that differ only in the high bits, or only in the alignment bits, must reach the same entry; a design that slices the wrong bits would return a different entry's value. The compare is exercised with a single mismatched top bit and a single mismatched low bit, which catches a compare that only looks at 32 bits. Verify requests with the valid bit low but with junk data on the bus confirm that no stray writes happen.

// File: rtl/ldvp_pkg.sv
package ldvp_pkg;
  localparam int unsigned PC_W_DEF   = 32;
  localparam int unsigned IDX_W_DEF  = 10;
  localparam int unsigned VAL_W_DEF  = 64;
  localparam int unsigned PC_LSB_DEF = 2;
endpackage

// File: rtl/ldvp_store.sv
module ldvp_store #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned VAL_W = 64,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             rd_vld,
  output logic [IDX_W-1:0] rd_idx,
  output logic [VAL_W-1:0] rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [VAL_W-1:0] wr_data
);
  logic [VAL_W-1:0] slots [DEPTH];

  // The read samples the array before this edge's write, so a read and a
  // write to the same slot in one cycle return the old contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      rd_vld <= 1'b0;
      rd_idx <= '0;
      rd_val <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        rd_idx <= rd_addr;
        rd_val <= slots[rd_addr];
      end
      if (wr_en) slots[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/ldvp_verify.sv
module ldvp_verify #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [VAL_W-1:0] in_pred,
  input  logic [VAL_W-1:0] in_act,
  output logic             out_vld,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_idx,
  output logic [VAL_W-1:0] out_val
);
  function automatic logic same_value(input logic [VAL_W-1:0] a,
                                      input logic [VAL_W-1:0] b);
    return ~|(a ^ b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_hit <= 1'b0;
      out_idx <= '0;
      out_val <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_hit <= same_value(in_pred, in_act);
        out_idx <= in_idx;
        out_val <= in_act;
      end
    end
  end
endmodule

// File: rtl/ldval_predictor.sv
module ldval_predictor
  import ldvp_pkg::*;
#(
  parameter int unsigned PC_W   = PC_W_DEF,
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned VAL_W  = VAL_W_DEF,
  parameter int unsigned PC_LSB = PC_LSB_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_vld,
  input  logic [PC_W-1:0]  lookup_pc,
  output logic             pred_vld,
  output logic [IDX_W-1:0] pred_idx,
  output logic [VAL_W-1:0] pred_val,
  input  logic             verify_vld,
  input  logic [IDX_W-1:0] verify_idx,
  input  logic [VAL_W-1:0] verify_pred,
  input  logic [VAL_W-1:0] verify_act,
  output logic             result_vld,
  output logic             result_hit,
  output logic [IDX_W-1:0] result_idx
);
  function automatic logic [IDX_W-1:0] pc_to_idx(input logic [PC_W-1:0] pc);
    return pc[PC_LSB +: IDX_W];
  endfunction

  // Named internal events, observed by the bound checker.
  logic [IDX_W-1:0] look_idx;
  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  logic [VAL_W-1:0] upd_val;

  assign look_idx = pc_to_idx(lookup_pc);

  ldvp_verify #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_verify (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (verify_vld),
    .in_idx  (verify_idx),
    .in_pred (verify_pred),
    .in_act  (verify_act),
    .out_vld (upd_en),
    .out_hit (result_hit),
    .out_idx (upd_idx),
    .out_val (upd_val)
  );

  assign result_vld = upd_en;
  assign result_idx = upd_idx;

  ldvp_store #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (lookup_vld),
    .rd_addr (look_idx),
    .rd_vld  (pred_vld),
    .rd_idx  (pred_idx),
    .rd_val  (pred_val),
    .wr_en   (upd_en),
    .wr_addr (upd_idx),
    .wr_data (upd_val)
  );
endmodule

// File: rtl/ldvp_checker.sv
module ldvp_checker #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned VAL_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lookup_vld,
  input logic [IDX_W-1:0] look_idx,
  input logic             pred_vld,
  input logic [IDX_W-1:0] pred_idx,
  input logic [VAL_W-1:0] pred_val,
  input logic             verify_vld,
  input logic [IDX_W-1:0] verify_idx,
  input logic [VAL_W-1:0] verify_pred,
  input logic [VAL_W-1:0] verify_act,
  input logic             result_vld,
  input logic             result_hit,
  input logic [IDX_W-1:0] result_idx,
  input logic             upd_en,
  input logic [IDX_W-1:0] upd_idx,
  input logic [VAL_W-1:0] upd_val
);
  assert_pred_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_vld |=> pred_vld);
  assert_pred_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_vld |=> !pred_vld);
  assert_pred_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_vld |=> pred_idx == $past(look_idx));
  assert_result_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    verify_vld |=> (result_vld && result_idx == $past(verify_idx)));
  assert_result_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !verify_vld |=> !result_vld);
  assert_hit_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verify_vld |=> result_hit == ($past(verify_act) == $past(verify_pred)));
  assert_write_actual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    verify_vld |=> (upd_en && upd_val == $past(verify_act)));
  assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_vld && $past(upd_en) && look_idx == $past(upd_idx)
     && !(upd_en && upd_idx == look_idx))
    |=> pred_val == $past(upd_val, 2));
endmodule

bind ldval_predictor ldvp_checker #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_ldvp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .lookup_vld  (lookup_vld),
  .look_idx    (look_idx),
  .pred_vld    (pred_vld),
  .pred_idx    (pred_idx),
  .pred_val    (pred_val),
  .verify_vld  (verify_vld),
  .verify_idx  (verify_idx),
  .verify_pred (verify_pred),
  .verify_act  (verify_act),
  .result_vld  (result_vld),
  .result_hit  (result_hit),
  .result_idx  (result_idx),
  .upd_en      (upd_en),
  .upd_idx     (upd_idx),
  .upd_val     (upd_val)
);

// File: tb/tb_ldval_predictor.sv
`timescale 1ns/1ps
module tb_ldval_predictor;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned VAL_W  = 64;
  localparam int unsigned PC_LSB = 2;
  localparam int unsigned DEPTH  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lookup_vld;
  logic [PC_W-1:0]  lookup_pc;
  logic             pred_vld;
  logic [IDX_W-1:0] pred_idx;
  logic [VAL_W-1:0] pred_val;
  logic             verify_vld;
  logic [IDX_W-1:0] verify_idx;
  logic [VAL_W-1:0] verify_pred;
  logic [VAL_W-1:0] verify_act;
  logic             result_vld;
  logic             result_hit;
  logic [IDX_W-1:0] result_idx;

  always #2 clk = ~clk;

  ldval_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .VAL_W(VAL_W), .PC_LSB(PC_LSB)) dut (
    .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld), .lookup_pc(lookup_pc),
    .pred_vld(pred_vld), .pred_idx(pred_idx), .pred_val(pred_val),
    .verify_vld(verify_vld), .verify_idx(verify_idx), .verify_pred(verify_pred),
    .verify_act(verify_act), .result_vld(result_vld), .result_hit(result_hit),
    .result_idx(result_idx));

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  logic [VAL_W-1:0] model [DEPTH];
  bit               pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [VAL_W-1:0] pend_val;

  logic [IDX_W-1:0] q_pidx [$];
  logic [VAL_W-1:0] q_pval [$];
  string            q_ptag [$];
  bit               q_rhit [$];
  logic [IDX_W-1:0] q_ridx [$];
  string            q_rtag [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [VAL_W-1:0] act, input logic [VAL_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one cycle of stimulus and pushes the expected results.
  task automatic step(input bit lv, input logic [PC_W-1:0] pc,
                      input bit vv, input logic [IDX_W-1:0] vi,
                      input logic [VAL_W-1:0] vp, input logic [VAL_W-1:0] va,
                      input string tag);
    logic [IDX_W-1:0] li;
    @(negedge clk);
    lookup_vld  = lv;
    lookup_pc   = pc;
    verify_vld  = vv;
    verify_idx  = vi;
    verify_pred = vp;
    verify_act  = va;
    li = pc[PC_LSB +: IDX_W];
    if (lv) begin
      q_pidx.push_back(li);
      q_pval.push_back(model[li]);
      q_ptag.push_back(tag);
    end
    // A verify from the previous cycle lands at the coming edge: lookups
    // made now still see the old value, later ones see the new value.
    if (pend_v) model[pend_idx] = pend_val;
    pend_v   = vv;
    pend_idx = vi;
    pend_val = va;
    if (vv) begin
      q_rhit.push_back(vp == va);
      q_ridx.push_back(vi);
      q_rtag.push_back(tag);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_of(input logic [IDX_W-1:0] idx);
    return {{(PC_W-IDX_W-PC_LSB){1'b0}}, idx, {PC_LSB{1'b0}}};
  endfunction

  // Monitor: each pushed item must appear at the very next clock edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (pred_vld) begin
        if (q_pidx.size() == 0)
          check(1'b0, "R2", "unexpected pred_vld", 1, 0);
        else begin
          check(pred_idx == q_pidx[0], {q_ptag[0], " R3"}, "pred_idx", pred_idx, q_pidx[0]);
          check(pred_val == q_pval[0], {q_ptag[0], " R4"}, "pred_val", pred_val, q_pval[0]);
          void'(q_pidx.pop_front()); void'(q_pval.pop_front()); void'(q_ptag.pop_front());
        end
      end else if (q_pidx.size() != 0) begin
        check(1'b0, "R2", "missing pred_vld", 0, 1);
        void'(q_pidx.pop_front()); void'(q_pval.pop_front()); void'(q_ptag.pop_front());
      end
      if (result_vld) begin
        if (q_rhit.size() == 0)
          check(1'b0, "R5", "unexpected result_vld", 1, 0);
        else begin
          check(result_idx == q_ridx[0], {q_rtag[0], " R5"}, "result_idx", result_idx, q_ridx[0]);
          check(result_hit == q_rhit[0], {q_rtag[0], " R6"}, "result_hit", result_hit, q_rhit[0]);
          void'(q_rhit.pop_front()); void'(q_ridx.pop_front()); void'(q_rtag.pop_front());
        end
      end else if (q_rhit.size() != 0) begin
        check(1'b0, "R5", "missing result_vld", 0, 1);
        void'(q_rhit.pop_front()); void'(q_ridx.pop_front()); void'(q_rtag.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VAL_W-1:0] va, vb, vc, vd;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    pend_v = 0; pend_idx = '0; pend_val = '0;
    rst_n = 1'b0;
    lookup_vld = 0; lookup_pc = '0;
    verify_vld = 0; verify_idx = '0; verify_pred = '0; verify_act = '0;
    repeat (3) @(negedge clk);
    check(!pred_vld, "R2", "pred_vld in reset", pred_vld, 0);
    check(!result_vld, "R5", "result_vld in reset", result_vld, 0);
    rst_n = 1'b1;

    va = 64'hDEADBEEF_01234567;
    vb = 64'h0F1E2D3C_4B5A6978;
    vc = 64'h11112222_33334444;
    vd = 64'h55556666_77778888;

    // R1: cleared contents, including both end entries
    step(1, pc_of(10'd0),    0, '0, '0, '0, "R1");
    step(1, pc_of(10'd1023), 0, '0, '0, '0, "R1");
    step(1, pc_of(10'd517),  0, '0, '0, '0, "R1");

    // R6 miss, then R8 same-cycle old value, then R7 new value
    step(0, '0, 1, 10'd5, '0, va, "R6 miss");
    step(1, pc_of(10'd5), 0, '0, '0, '0, "R8");
    step(1, pc_of(10'd5), 0, '0, '0, '0, "R7");
    step(0, '0, 1, 10'd5, va, va, "R6 hit");
    step(0, '0, 1, 10'd9, vb ^ {1'b1, 63'b0}, vb, "R6 top bit");
    step(0, '0, 1, 10'd9, vb ^ 64'd1, vb, "R6 low bit");
    step(0, '0, 0, '0, '0, '0, "idle");
    // R3 high address bits ignored, R9 low bits ignored
    step(1, {20'hABCDE, 10'd9, 2'b11}, 0, '0, '0, '0, "R3 R9 alias");
    step(1, {20'h00001, 10'd5, 2'b01}, 0, '0, '0, '0, "R3 R9 alias");

    // R10: junk on the verify bus with valid low must not write
    step(0, '0, 0, 10'd5, '1, vc, "R10");
    step(0, '0, 0, 10'd9, '1, vd, "R10");
    step(1, pc_of(10'd5), 0, '0, '0, '0, "R10");
    step(1, pc_of(10'd9), 0, '0, '0, '0, "R10");

    // R8 with back-to-back writes to one entry
    step(0, '0, 1, 10'd7, '0, vc, "R7");
    step(1, pc_of(10'd7), 1, 10'd7, vc, vd, "R8");
    step(1, pc_of(10'd7), 0, '0, '0, '0, "R7");
    step(1, pc_of(10'd7), 0, '0, '0, '0, "R7");

    // Mixed traffic over a small index set to force aliasing (R4)
    for (int i = 0; i < 600; i++) begin
      logic [IDX_W-1:0] vi;
      logic [VAL_W-1:0] pv, av;
      vi = IDX_W'($urandom % 16);
      av = {$urandom, $urandom};
      pv = ($urandom % 2) ? av : {$urandom, $urandom};
      step($urandom % 2, {$urandom} & 32'hFFFF_F03F, $urandom % 2, vi, pv, av, "R4 mixed");
    end
    step(0, '0, 0, '0, '0, '0, "drain");
    step(0, '0, 0, '0, '0, '0, "drain");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule